// File: doc/BRIEF.md
# Burst Read Ready Wait Generator

This block produces the ready indication for a synchronous memory that streams words in bursts. When a host starts a burst, it supplies a starting word address. The block then holds ready low through a fixed initial latency. After that it delivers one word per clock, each marked by a data-valid strobe. Whenever the word just delivered sits at the top of a 64-word page, the block drops ready again so that the host inserts wait clocks before the next page's data arrives.

A small configuration register selects the length of each page-crossing wait: one clock, which is the reset setting, or two clocks. Each burst takes a snapshot of this setting when it starts, so the wait length never changes partway through a burst. Between bursts, ready stays high and data-valid stays low.

Top module: `burst_wait_gen`

## Requirements
- R1: After reset, and whenever no burst is running, ready is 1 and data_valid is 0.
- R2: A burst_start sampled on a clock edge loads start_addr and begins the initial access. From the next cycle, ready and data_valid are both 0 for exactly LATENCY cycles (default 4).
- R3: After the initial access, each cycle delivers one word with ready and data_valid both 1. The word address advances by one per word, and data_valid is never 1 while ready is 0.
- R4: When the word delivered has its low six address bits equal to 6'h3F, ready and data_valid are 0 for the wait length in the following cycles. Streaming then resumes at the next address.
- R5: The wait-length register resets to 0, which means one wait clock. A cfg_we pulse stores cfg_two_wait in it, and a value of 1 means two wait clocks.
- R6: A burst uses the register value held on the edge where burst_start is sampled. A write in that same cycle, or any later write, affects only later bursts.
- R7: If burst_active is 0 on an edge without burst_start, the block is idle from the next cycle. A burst_start always takes priority and restarts the burst, even mid-burst.
- R8: If the start address has its low six bits at 6'h3F, the page-crossing wait follows the very first delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | Begin a burst at start_addr |
| start_addr | input | ADDR_W | First word address of the burst |
| burst_active | input | 1 | Host keeps the burst running while 1 |
| cfg_we | input | 1 | Write strobe for the wait-length setting |
| cfg_two_wait | input | 1 | Setting to write: 1 selects two-clock waits |
| ready | output | 1 | 0 means the host must wait |
| data_valid | output | 1 | A word is delivered this cycle |

## Verification
Two events can coincide in one cycle:
- a configuration write and the burst start that snapshots the setting;
- a new burst_start and a burst already streaming.

The bench drives a write of 1 in the same cycle as a start. It then expects a single wait clock at the first page crossing, because the burst must use the old value. It also restarts a burst mid-stream and expects ready to fall at once into a fresh initial access with the new setting. A behavioural model, compared every cycle, judges the long streams across page crossings.

// File: rtl/burst_wait_gen.sv
module burst_wait_gen #(
  parameter int ADDR_W    = 22,
  parameter int LATENCY   = 4,
  parameter int PAGE_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              burst_active,
  input  logic              cfg_we,
  input  logic              cfg_two_wait,
  output logic              ready,
  output logic              data_valid
);
  localparam int CNT_W = $clog2(LATENCY > 2 ? LATENCY : 2);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_STREAM, S_WAIT} state_t;

  state_t            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cfg_q;
  logic              two_q;
  logic              at_edge;
  logic              busy;

  assign at_edge = (state_q == S_STREAM) && (&addr_q[PAGE_BITS-1:0]);
  assign busy    = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= 1'b0;
    else if (cfg_we) cfg_q <= cfg_two_wait;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      two_q   <= 1'b0;
    end else if (burst_start) begin
      state_q <= S_INIT;
      addr_q  <= start_addr;
      cnt_q   <= CNT_W'(LATENCY - 1);
      two_q   <= cfg_q;
    end else if (!burst_active) begin
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_INIT, S_WAIT: begin
          if (cnt_q == '0) state_q <= S_STREAM;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        S_STREAM: begin
          addr_q <= addr_q + 1'b1;
          if (at_edge) begin
            state_q <= S_WAIT;
            cnt_q   <= two_q ? CNT_W'(1) : '0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ready      = (state_q == S_IDLE) || (state_q == S_STREAM);
  assign data_valid = (state_q == S_STREAM);
endmodule

module burst_wait_gen_chk #(
  parameter int LATENCY = 4
) (
  input logic clk,
  input logic rst_n,
  input logic burst_start,
  input logic burst_active,
  input logic ready,
  input logic data_valid,
  input logic at_edge,
  input logic busy,
  input logic two_q
);
  localparam int MAXLOW = LATENCY > 2 ? LATENCY : 2;
  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (!rst_n || burst_start || ready) low_run <= 0;
    else if (low_run < MAXLOW + 1)      low_run <= low_run + 1;
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_active && !burst_start) |=> (ready && !data_valid)); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (!ready && !data_valid)); // R2
  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= MAXLOW); // R4
  AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !data_valid); // R3
  AST_EDGE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (at_edge && burst_active && !burst_start) |=> (!ready && !data_valid)); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !burst_start) |=> $stable(two_q)); // R6
endmodule

bind burst_wait_gen burst_wait_gen_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_start(burst_start),
  .burst_active(burst_active), .ready(ready), .data_valid(data_valid),
  .at_edge(at_edge), .busy(busy), .two_q(two_q)
);

// File: tb/test_burst_wait_gen.sv
`timescale 1ns/1ps
module test_burst_wait_gen;
  localparam int AW  = 22;
  localparam int LAT = 4;

  logic clk = 0, rst_n = 0;
  logic burst_start = 0, burst_active = 0, cfg_we = 0, cfg_two_wait = 0;
  logic [AW-1:0] start_addr = '0;
  logic ready, data_valid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_wait_gen #(.ADDR_W(AW), .LATENCY(LAT)) i_burst_wait_gen (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .start_addr(start_addr),
    .burst_active(burst_active), .cfg_we(cfg_we), .cfg_two_wait(cfg_two_wait),
    .ready(ready), .data_valid(data_valid));

  // behavioural reference: 0 idle, 1 initial access, 2 delivering, 3 page wait
  int ph = 0, rem = 0;
  longint unsigned maddr = 0;
  bit mcfg = 0, mtwo = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; mcfg = 0; mtwo = 0;
    end else begin
      bit oldcfg;
      oldcfg = mcfg;
      if (cfg_we) mcfg = cfg_two_wait;
      if (burst_start) begin
        ph = 1; rem = LAT; maddr = start_addr; mtwo = oldcfg;
      end else if (!burst_active) ph = 0;
      else if (ph == 1 || ph == 3) begin
        rem = rem - 1;
        if (rem == 0) ph = 2;
      end else if (ph == 2) begin
        if (maddr % 64 == 63) begin ph = 3; rem = mtwo ? 2 : 1; end
        maddr = (maddr + 1) % (64'd1 << AW);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit er, ev;
      string tag;
      er = (ph == 0 || ph == 2);
      ev = (ph == 2);
      tag = (ph == 0) ? "R1" : (ph == 1) ? "R2" : (ph == 2) ? "R3" : "R4";
      checks++;
      if (ready !== er || data_valid !== ev) begin
        fails++;
        $display("FAIL %s model: ready/valid actual %b%b expected %b%b", tag, ready, data_valid, er, ev);
      end
    end
  end

  task automatic tick(input bit bs, input logic [AW-1:0] a, input bit act,
                      input bit we, input bit wd, input string tag, input bit er, input bit ev);
    @(posedge clk); #1;
    burst_start = bs; start_addr = a; burst_active = act; cfg_we = we; cfg_two_wait = wd;
    @(negedge clk);
    checks++;
    if (ready !== er || data_valid !== ev) begin
      fails++;
      $display("FAIL %s: ready/valid actual %b%b expected %b%b", tag, ready, data_valid, er, ev);
    end
  endtask

  task automatic run(input bit act);
    @(posedge clk); #1;
    burst_start = 0; burst_active = act; cfg_we = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 reset state
    if (ready !== 1'b1 || data_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual %b%b expected 10", ready, data_valid);
    end
    @(posedge clk); #1 rst_n = 1;

    // R2 R3 R4 R5: default one-clock wait crossing 3F
    tick(1, 22'h3E, 1, 0, 0, "R1", 1, 0);
    for (int i = 0; i < LAT; i++) tick(0, 0, 1, 0, 0, "R2", 0, 0);
    tick(0, 0, 1, 0, 0, "R3", 1, 1);
    tick(0, 0, 1, 0, 0, "R3", 1, 1);
    tick(0, 0, 1, 0, 0, "R5", 0, 0);
    tick(0, 0, 1, 0, 0, "R4", 1, 1);
    tick(0, 0, 0, 0, 0, "R3", 1, 1);
    tick(0, 0, 0, 0, 0, "R7", 1, 0);

    // R6: two-clock mode, write during init must not shorten the wait
    tick(0, 0, 0, 1, 1, "R1", 1, 0);
    tick(1, 22'h3E, 1, 0, 0, "R1", 1, 0);
    tick(0, 0, 1, 1, 0, "R2", 0, 0);
    for (int i = 1; i < LAT; i++) tick(0, 0, 1, 0, 0, "R2", 0, 0);
    tick(0, 0, 1, 0, 0, "R3", 1, 1);
    tick(0, 0, 1, 0, 0, "R3", 1, 1);
    tick(0, 0, 1, 0, 0, "R6", 0, 0);
    tick(0, 0, 1, 0, 0, "R6", 0, 0);
    tick(0, 0, 1, 0, 0, "R4", 1, 1);
    tick(0, 0, 0, 0, 0, "R3", 1, 1);
    tick(0, 0, 0, 0, 0, "R7", 1, 0);

    // R6 + R8: write of 1 in the start cycle is not seen; start at 3F
    tick(1, 22'h13F, 1, 1, 1, "R1", 1, 0);
    for (int i = 0; i < LAT; i++) tick(0, 0, 1, 0, 0, "R2", 0, 0);
    tick(0, 0, 1, 0, 0, "R8", 1, 1);
    tick(0, 0, 1, 0, 0, "R8", 0, 0);
    tick(0, 0, 1, 0, 0, "R6", 1, 1);

    // R7: restart mid-stream, now with two-clock waits
    tick(1, 22'h10, 1, 0, 0, "R3", 1, 1);
    for (int i = 0; i < LAT; i++) tick(0, 0, 1, 0, 0, "R7", 0, 0);
    tick(0, 0, 1, 0, 0, "R7", 1, 1);

    // long stream across a page crossing, judged by the model
    for (int i = 0; i < 150; i++) run(1);
    // restart repeatedly near boundaries
    tick(1, 22'h3FFFBF, 1, 1, 0, "R7", 1, 1);
    for (int i = 0; i < 80; i++) run(1);
    run(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule